// File: doc/BRIEF.md
# Microcode Control Store Access Unit

This block gives a microprogrammed processor read and write access to its own writable control store, a 1024-word memory of 32-bit microinstructions, and read access to a parallel read-only store of the same shape. A 16-bit selector register is loaded from the processor and picks the store, the half of the word to return, and the word address. A single-cycle read strobe returns one 16-bit half of the selected word. The block does not drive the processor bus exclusively: its output is meant to be ANDed with the other bus drivers, so it shows all ones whenever it has nothing to return.

A single-cycle write strobe updates a whole 32-bit word from two sources over two cycles. The high half is the M register value sampled at the end of the strobe cycle. The low half is the ALU result sampled at the end of the following cycle, which is also when the word is committed. Writes aimed at the read-only store are dropped. Stored words keep the processor's microinstruction encoding, including the fields kept with their top bit inverted. The block stores exactly what it is given.

Bit positions below use vector numbering, with [15] as the most significant bit. The read-only store contents come from a closed-form function of the word address.

Top module: `ucs_access`

## Requirements
- R1: After reset the bus output is 16'hFFFF and the selector register holds zero, so a strobe issued before any load addresses RAM word 0, low half.
- R2: In a cycle with `sel_load` high, the selector register takes `sel_in` at the clock edge. Otherwise it holds its value. Field layout: [11] selects the store (0 RAM, 1 ROM), [10] selects the read half, [9:0] is the word address, and [15:12] are not decoded. A strobe in the same cycle as a load uses the previous selector value.
- R3: A read strobe in cycle N places the selected half of the addressed word on `bus_and_o` during cycle N+1. The word is taken from the store contents as they stand during cycle N.
- R4: Half select [10] = 1 returns word bits [31:16], and [10] = 0 returns bits [15:0].
- R5: With [11] = 1, reads come from the read-only store. ROM word a has a high half of 16'hA800 OR a, and a low half equal to the bitwise complement of a zero-extended to 16 bits.
- R6: In any cycle that does not follow a read strobe, `bus_and_o` is 16'hFFFF.
- R7: A write strobe in cycle N, with no write pending, writes word {m_in sampled at the end of cycle N, alu_in sampled at the end of cycle N+1} to RAM at the address held in cycle N. The word is committed at the end of cycle N+1. Reads strobed in cycle N+1 or earlier return the old word, and reads strobed from cycle N+2 on return the new word.
- R8: A write ignores the half-select bit [10]. Both halves are written in either case.
- R9: A write whose selector has [11] = 1 changes nothing: the RAM word at that address and the ROM contents read back unchanged.
- R10: A write strobe in the cycle right after an accepted write strobe is ignored.
- R11: Microinstructions are stored with bit 0 as the MSB of each half. The function-1 field (high half, bits 12-15), the function-2 field (low half, bits 0-3) and the load-L bit (low half, bit 5) are stored with their top bit inverted. Take R=0, ALU=0, bus source=5, F1=2, F2=0, LoadT=0, LoadL=1 and next address 325 octal. This word encodes as 132 octal (high) and 100325 octal (low), and it reads back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_load | input | 1 | Load the selector register from `sel_in` |
| sel_in | input | 16 | Selector value (store, half, word address) |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| m_in | input | 16 | M register value, source of the high half |
| alu_in | input | 16 | ALU result, source of the low half |
| bus_and_o | output | 16 | Read data for the AND-combined processor bus, all ones when idle |

## Verification
Read data is due exactly one cycle after its strobe, and every other cycle must show all ones. The reference model in the bench therefore predicts the bus value for every single cycle and compares it at the falling edge after each rising edge. A write is due in the store at the end of the cycle after its strobe. The model updates its array at that edge, after it has computed the read result for the same edge, so a read strobed in the commit cycle is expected to return the old word. Reads strobed two cycles after the write strobe are expected to return the new word. Ignored strobes are checked by reading back the words they could have changed.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
    localparam int unsigned HALF_W    = 16;
    localparam int unsigned WADDR_W   = 10;
    localparam int unsigned WORD_W    = 2 * HALF_W;
    localparam int unsigned HALF_BIT  = WADDR_W;      // read half select
    localparam int unsigned STORE_BIT = WADDR_W + 1;  // 1 = read-only store
    localparam logic [HALF_W-1:0] ROM_HI_TAG = 16'hA800;

    // Closed-form read-only store contents
    function automatic logic [WORD_W-1:0] rom_word(input logic [WADDR_W-1:0] a);
        logic [HALF_W-1:0] ext;
        ext = HALF_W'(a);
        return {ROM_HI_TAG | ext, ~ext};
    endfunction
endpackage

// File: rtl/ucs_rom.sv
module ucs_rom #(
    parameter int unsigned WADDR_W = ucs_pkg::WADDR_W,
    parameter int unsigned WORD_W  = ucs_pkg::WORD_W
) (
    input  logic [WADDR_W-1:0] addr,
    output logic [WORD_W-1:0]  word
);
    always_comb begin
        word = WORD_W'(ucs_pkg::rom_word(ucs_pkg::WADDR_W'(addr)));
    end
endmodule

// File: rtl/ucs_ram.sv
module ucs_ram #(
    parameter int unsigned WADDR_W = ucs_pkg::WADDR_W,
    parameter int unsigned WORD_W  = ucs_pkg::WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [WADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [WADDR_W-1:0] raddr,
    output logic [WORD_W-1:0]  rdata
);
    localparam int unsigned DEPTH = 1 << WADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // Committed word is visible at its address after the edge (R7)
    assert_commit_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/ucs_wseq.sv
module ucs_wseq #(
    parameter int unsigned HALF_W  = ucs_pkg::HALF_W,
    parameter int unsigned WADDR_W = ucs_pkg::WADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic                rom_sel,
    input  logic [WADDR_W-1:0]  waddr_in,
    input  logic [HALF_W-1:0]   m_in,
    input  logic [HALF_W-1:0]   alu_in,
    output logic                commit_o,
    output logic [WADDR_W-1:0]  caddr_o,
    output logic [2*HALF_W-1:0] cdata_o
);
    typedef struct packed {
        logic               pend;
        logic               rom;
        logic [WADDR_W-1:0] addr;
        logic [HALF_W-1:0]  hi;
    } wseq_t;

    wseq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pend) begin
            // commit cycle: any new strobe here is dropped
            st_d.pend = 1'b0;
        end else if (wr_stb) begin
            st_d.pend = 1'b1;
            st_d.rom  = rom_sel;
            st_d.addr = waddr_in;
            st_d.hi   = m_in;
        end
        commit_o = st_q.pend && !st_q.rom;
        caddr_o  = st_q.addr;
        cdata_o  = {st_q.hi, alu_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !st_q.pend) |=> st_q.pend);

    assert_back_to_back_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> !st_q.pend);

    assert_rom_write_discarded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !st_q.pend && rom_sel) |=> !commit_o);

    assert_hi_and_addr_captured_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !st_q.pend && !rom_sel) |=>
            (commit_o && cdata_o[2*HALF_W-1:HALF_W] == $past(m_in) && caddr_o == $past(waddr_in)));
endmodule

// File: rtl/ucs_access.sv
module ucs_access #(
    parameter int unsigned HALF_W  = ucs_pkg::HALF_W,
    parameter int unsigned WADDR_W = ucs_pkg::WADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_load,
    input  logic [HALF_W-1:0] sel_in,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [HALF_W-1:0] m_in,
    input  logic [HALF_W-1:0] alu_in,
    output logic [HALF_W-1:0] bus_and_o
);
    localparam int unsigned WORD_W    = 2 * HALF_W;
    localparam int unsigned HALF_BIT  = WADDR_W;
    localparam int unsigned STORE_BIT = WADDR_W + 1;

    typedef struct packed {
        logic [HALF_W-1:0] sel;
        logic [HALF_W-1:0] bus;
    } top_t;

    top_t cur_d, cur_q;

    logic [WADDR_W-1:0] word_addr;
    logic               rom_pick;
    logic               hi_pick;
    logic [WORD_W-1:0]  ram_word, rom_word_v, picked_word;
    logic [HALF_W-1:0]  half_val;
    logic               commit;
    logic [WADDR_W-1:0] commit_addr;
    logic [WORD_W-1:0]  commit_data;

    assign word_addr = cur_q.sel[WADDR_W-1:0];
    assign rom_pick  = cur_q.sel[STORE_BIT];
    assign hi_pick   = cur_q.sel[HALF_BIT];

    ucs_ram #(.WADDR_W(WADDR_W), .WORD_W(WORD_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .waddr (commit_addr),
        .wdata (commit_data),
        .raddr (word_addr),
        .rdata (ram_word)
    );

    ucs_rom #(.WADDR_W(WADDR_W), .WORD_W(WORD_W)) u_rom (
        .addr (word_addr),
        .word (rom_word_v)
    );

    ucs_wseq #(.HALF_W(HALF_W), .WADDR_W(WADDR_W)) u_wseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .rom_sel  (rom_pick),
        .waddr_in (word_addr),
        .m_in     (m_in),
        .alu_in   (alu_in),
        .commit_o (commit),
        .caddr_o  (commit_addr),
        .cdata_o  (commit_data)
    );

    always_comb begin
        picked_word = rom_pick ? rom_word_v : ram_word;
        half_val    = hi_pick ? picked_word[WORD_W-1:HALF_W] : picked_word[HALF_W-1:0];

        cur_d = cur_q;
        if (sel_load) begin
            cur_d.sel = sel_in;
        end
        cur_d.bus = rd_stb ? half_val : '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.sel <= '0;
            cur_q.bus <= '1;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign bus_and_o = cur_q.bus;

    assert_idle_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> bus_and_o == '1);

    assert_read_one_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> bus_and_o == $past(half_val));

    assert_selector_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_load |=> $stable(cur_q.sel));
endmodule

// File: tb/ucs_access_tb.sv
`timescale 1ns/1ps
module ucs_access_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_load = 1'b0;
    logic [15:0] sel_in = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] m_in = '0;
    logic [15:0] alu_in = '0;
    logic [15:0] bus_and_o;

    always #2.5 clk = ~clk;

    ucs_access u_dut (
        .clk(clk), .rst_n(rst_n), .sel_load(sel_load), .sel_in(sel_in),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .m_in(m_in), .alu_in(alu_in),
        .bus_and_o(bus_and_o)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    string tag = "R1";

    // behavioural reference model
    logic [31:0] ref_ram [int];
    logic [15:0] ref_sel = '0;
    bit          ref_pend = 0;
    bit          ref_prom = 0;
    int          ref_paddr = 0;
    logic [15:0] ref_phi = '0;
    logic [15:0] exp_bus = 16'hFFFF;

    function automatic logic [31:0] rom_ref(int a);
        logic [15:0] hi, lo;
        hi = 16'hA800 + 16'(a);
        lo = 16'hFFFF - 16'(a);
        return {hi, lo};
    endfunction

    function automatic logic [15:0] mk_sel(bit rom, bit hi, int a);
        return 16'(rom) * 16'd2048 + 16'(hi) * 16'd1024 + 16'(a);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(bit ld, logic [15:0] sv, bit rd, bit wr, logic [15:0] m, logic [15:0] alu);
        logic [31:0] w;
        sel_load = ld; sel_in = sv; rd_stb = rd; wr_stb = wr; m_in = m; alu_in = alu;
        // predict the bus for the next cycle from state before the edge
        if (rd) begin
            if (ref_sel[11]) w = rom_ref(int'(ref_sel[9:0]));
            else if (ref_ram.exists(int'(ref_sel[9:0]))) w = ref_ram[int'(ref_sel[9:0])];
            else w = 'x;
            exp_bus = ref_sel[10] ? w[31:16] : w[15:0];
        end else begin
            exp_bus = 16'hFFFF;
        end
        if (ref_pend) begin
            if (!ref_prom) ref_ram[ref_paddr] = {ref_phi, alu};
            ref_pend = 0;
        end else if (wr) begin
            ref_pend = 1; ref_prom = ref_sel[11];
            ref_paddr = int'(ref_sel[9:0]); ref_phi = m;
        end
        if (ld) ref_sel = sv;
        @(posedge clk);
        @(negedge clk);
        check(tag, bus_and_o, exp_bus);
    endtask

    task automatic idle();
        cyc(0, '0, 0, 0, '0, '0);
    endtask

    task automatic do_write(logic [15:0] sv, logic [15:0] hi, logic [15:0] lo);
        cyc(1, sv, 0, 0, '0, '0);
        cyc(0, '0, 0, 1, hi, 16'h0BAD);
        cyc(0, '0, 0, 0, 16'hDEAD, lo);
    endtask

    task automatic do_read(bit rom, bit hi, int a);
        cyc(1, mk_sel(rom, hi, a), 0, 0, '0, '0);
        cyc(0, '0, 1, 0, '0, '0);
        idle();
    endtask

    initial begin
        logic [15:0] ehi, elo;
        repeat (3) @(negedge clk);
        tag = "R1";
        check("R1", bus_and_o, 16'hFFFF);
        rst_n = 1'b1;
        idle(); idle();

        // R1: selector is zero after reset -> write/read word 0 low half
        tag = "R1";
        cyc(0, '0, 0, 1, 16'h1234, '0);
        cyc(0, '0, 0, 0, '0, 16'h5678);
        idle();
        cyc(0, '0, 1, 0, '0, '0);
        idle();

        // R4: both halves
        tag = "R4";
        do_read(0, 1, 0);
        do_read(0, 0, 0);

        // R6: long idle stretch
        tag = "R6";
        repeat (5) idle();

        // R11: encoded microinstruction example
        tag = "R11";
        ehi = {5'd0, 4'd0, 3'd5, 4'd2 ^ 4'b1000};
        elo = {4'd0 ^ 4'b1000, 1'b0, 1'b1 ^ 1'b1, 10'o325};
        check("R11", ehi, 16'o132);
        check("R11", elo, 16'o100325);
        do_write(mk_sel(0, 0, 10'o325), ehi, elo);
        do_read(0, 1, 10'o325);
        do_read(0, 0, 10'o325);

        // R8: half select set during write
        tag = "R8";
        do_write(mk_sel(0, 1, 5), 16'hAAAA, 16'h5555);
        do_read(0, 1, 5);
        do_read(0, 0, 5);

        // R9: write aimed at ROM is discarded
        tag = "R9";
        do_write(mk_sel(0, 0, 7), 16'h7070, 16'h0707);
        do_write(mk_sel(1, 0, 7), 16'hFEED, 16'hBEEF);
        do_read(0, 1, 7);
        do_read(0, 0, 7);
        do_read(1, 1, 7);
        do_read(1, 0, 7);

        // R10: second strobe right after an accepted one is ignored
        tag = "R10";
        do_write(mk_sel(0, 0, 10), 16'h1010, 16'h0A0A);
        cyc(1, mk_sel(0, 0, 9), 0, 0, '0, '0);
        cyc(1, mk_sel(0, 0, 10), 0, 1, 16'h9999, '0);   // accepted at word 9
        cyc(0, '0, 0, 1, 16'h4444, 16'h9A9A);           // dropped
        cyc(0, '0, 0, 0, '0, 16'h3333);
        idle();
        do_read(0, 1, 10);
        do_read(0, 0, 10);
        do_read(0, 1, 9);
        do_read(0, 0, 9);

        // R7: reads around the commit edge
        tag = "R7";
        do_write(mk_sel(0, 1, 12), 16'h0C0C, 16'hC0C0);
        cyc(1, mk_sel(0, 0, 12), 0, 0, '0, '0);
        cyc(0, '0, 1, 1, 16'h1111, '0);     // strobe cycle: old
        cyc(0, '0, 1, 0, '0, 16'h2222);     // commit cycle: old
        cyc(0, '0, 1, 0, '0, '0);           // new
        cyc(1, mk_sel(0, 1, 12), 0, 0, '0, '0);
        cyc(0, '0, 1, 0, '0, '0);
        idle();

        // R5: ROM contents at edges and middle
        tag = "R5";
        foreach (ehi[i]) begin
            do_read(1, i[0], i * 64 + i);
        end
        do_read(1, 0, 1023);
        do_read(1, 1, 1023);

        // R2/R3: load and read in the same cycle uses the old selector
        tag = "R2";
        cyc(1, mk_sel(0, 0, 5), 0, 0, '0, '0);
        cyc(1, mk_sel(1, 1, 3), 1, 0, '0, '0);
        cyc(0, '0, 1, 0, '0, '0);
        cyc(1, 16'hF000 | mk_sel(0, 1, 5), 0, 0, '0, '0);  // undecoded bits set
        cyc(0, '0, 1, 0, '0, '0);

        // R3: sweep of writes and back-to-back reads
        tag = "R3";
        for (int k = 0; k < 16; k++) begin
            do_write(mk_sel(0, 0, 100 + k * 37), 16'(k * 16'h0101), 16'(16'hF00F ^ 16'(k)));
        end
        for (int k = 0; k < 16; k++) begin
            cyc(1, mk_sel(0, k % 2 == 1, 100 + k * 37), 0, 0, '0, '0);
            cyc(0, '0, 1, 0, '0, '0);
        end
        idle();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule